// File: doc/BRIEF.md
# Serial-Input QAM Symbol Combiner

The combiner turns a serial bit stream into quadrature amplitude modulated samples. Incoming bits are gathered into symbols of two bits (4-QAM) or four bits (16-QAM), depending on a mode input. A symbol-boundary strobe moves the most recently completed symbol into a holding register. The held symbol then sets two signed coefficients, taken from the set ±1 and ±3.

On every clock the block multiplies an in-phase carrier sample (S0) and a quadrature carrier sample (S1) by those coefficients, adds the two products and registers the result. The carriers come from an external generator as cosine and sine. The output is wide enough for the full-scale ±3S0±3S1 case.

Top module: `qam_symbol_combiner`

## Requirements
- R1: Bits are taken only in cycles where `bit_valid` is high. In 4-QAM mode (`mode_16`=0) a symbol is complete after two accepted bits. In 16-QAM mode (`mode_16`=1) it is complete after four. The first bit accepted in a group becomes the symbol's most significant bit.
- R2: In 4-QAM mode the held symbol bits [1:0] select the output: 00 gives S0+S1, 01 gives S0−S1, 10 gives −S0+S1, 11 gives −S0−S1.
- R3: In 16-QAM mode, held symbol bits [1:0] set the S0 coefficient: 00 gives +1, 01 gives +3, 10 gives −1, 11 gives −3.
- R4: In 16-QAM mode, held symbol bits [3:2] set the S1 coefficient using the same code as R3.
- R5: On a clock edge with `sym_strobe` high, the holding register loads the last symbol completed before that edge. It changes on no other edge. If no symbol has completed since reset, the strobe loads symbol 0.
- R6: On an edge where `mode_16` differs from its value at the previous edge, any partly gathered group is dropped. A bit accepted on that edge becomes the first bit of a new group.
- R7: `sample_out` is SAMPLE_W+3 bits, two's complement, and equals the exact sum with no wrap, including when both carriers are at negative full scale.
- R8: `sample_out` is registered. After edge k it shows the combination of the carrier values present at edge k, using the symbol held before edge k and `mode_16` at edge k.
- R9: Reset clears `sample_out` to 0 and the holding register to symbol 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_16 | input | 1 | 0 selects 4-QAM, 1 selects 16-QAM |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Qualifies `bit_in` |
| sym_strobe | input | 1 | Symbol boundary; loads the holding register |
| carrier_i | input | SAMPLE_W | Signed in-phase carrier sample S0 |
| carrier_q | input | SAMPLE_W | Signed quadrature carrier sample S1 |
| sample_out | output | SAMPLE_W+3 | Signed modulated sample |

## Verification
The assertions take the carrier samples as any two's complement values, including the most negative value. From this they bound the output by six times full scale in 16-QAM mode and by twice full scale in 4-QAM mode. They also expect the mode input to be stable around the edge in which it is sampled. The stimulus holds the mode fixed for long stretches and changes it only at the falling clock edge. It draws carriers over the whole signed range and inserts both negative full-scale extremes on purpose.

// File: rtl/qam_comb_pkg.sv
package qam_comb_pkg;
   localparam int SYM_W = 4;   // widest symbol (16-QAM)

   typedef logic [SYM_W-1:0] sym_t;

   // One carrier weight: sign and magnitude select (1 or 3)
   typedef struct packed {
      logic neg;
      logic triple;
   } weight_t;

   // Two-bit weight code used by 16-QAM: bit1 = negate, bit0 = times three
   function automatic weight_t decode_pair(input logic [1:0] code);
      weight_t w;
      w.neg    = code[1];
      w.triple = code[0];
      return w;
   endfunction
endpackage

// File: rtl/qam_bit_gatherer.sv
module qam_bit_gatherer
   import qam_comb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mode_16,
   input  logic bit_in,
   input  logic bit_valid,
   output sym_t done_sym
);
   localparam int CNT_W = $clog2(SYM_W);

   logic [SYM_W-2:0] shreg;
   logic [CNT_W-1:0] cnt;
   logic             mode_q;
   logic [CNT_W-1:0] last_idx;
   sym_t             next_sym;

   assign last_idx = mode_16 ? CNT_W'(SYM_W - 1) : CNT_W'(1);
   assign next_sym = mode_16 ? {shreg, bit_in}
                             : {{(SYM_W-2){1'b0}}, shreg[0], bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         cnt      <= '0;
         mode_q   <= 1'b0;
         done_sym <= '0;
      end else begin
         mode_q <= mode_16;
         if (bit_valid) shreg <= {shreg[SYM_W-3:0], bit_in};
         if (mode_16 != mode_q) begin
            cnt <= bit_valid ? CNT_W'(1) : '0;
         end else if (bit_valid) begin
            if (cnt == last_idx) begin
               cnt      <= '0;
               done_sym <= next_sym;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/qam_weight_map.sv
module qam_weight_map
   import qam_comb_pkg::*;
(
   input  sym_t    sym,
   input  logic    mode_16,
   output weight_t w_i,
   output weight_t w_q
);
   always_comb begin
      if (mode_16) begin
         w_i = decode_pair(sym[1:0]);
         w_q = decode_pair(sym[3:2]);
      end else begin
         w_i = '{neg: sym[1], triple: 1'b0};
         w_q = '{neg: sym[0], triple: 1'b0};
      end
   end
endmodule

// File: rtl/qam_scaled_term.sv
module qam_scaled_term
   import qam_comb_pkg::*;
#(
   parameter int IN_W      = 12,
   parameter int OUT_W     = IN_W + 3,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic signed [IN_W-1:0]  x,
   input  weight_t                 w,
   output logic signed [OUT_W-1:0] y
);
   logic signed [OUT_W-1:0] ext;
   logic signed [OUT_W-1:0] mag;

   assign ext = OUT_W'(x);

   generate
      if (SHIFT_ADD) begin : g_shift
         assign mag = w.triple ? (ext <<< 1) + ext : ext;
      end else begin : g_mult
         logic signed [OUT_W-1:0] factor;
         assign factor = w.triple ? OUT_W'(3) : OUT_W'(1);
         assign mag    = OUT_W'(ext * factor);
      end
   endgenerate

   assign y = w.neg ? -mag : mag;
endmodule

// File: rtl/qam_symbol_combiner.sv
module qam_symbol_combiner
   import qam_comb_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mode_16,
   input  logic                        bit_in,
   input  logic                        bit_valid,
   input  logic                        sym_strobe,
   input  logic signed [SAMPLE_W-1:0]  carrier_i,
   input  logic signed [SAMPLE_W-1:0]  carrier_q,
   output logic signed [SAMPLE_W+2:0]  sample_out
);
   localparam int OUT_W = SAMPLE_W + 3;

   initial begin
      if (SAMPLE_W < 2) $error("SAMPLE_W must be at least 2");
      if (SYM_W != 4)   $error("symbol width must be 4");
   end

   sym_t    done_sym;
   sym_t    hold_sym;
   weight_t w_i, w_q;
   logic signed [OUT_W-1:0] term_i, term_q;

   qam_bit_gatherer u_gather (
      .clk(clk), .rst_n(rst_n), .mode_16(mode_16),
      .bit_in(bit_in), .bit_valid(bit_valid), .done_sym(done_sym)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold_sym <= '0;
      else if (sym_strobe) hold_sym <= done_sym;
   end

   qam_weight_map u_map (
      .sym(hold_sym), .mode_16(mode_16), .w_i(w_i), .w_q(w_q)
   );

   qam_scaled_term #(.IN_W(SAMPLE_W), .OUT_W(OUT_W), .SHIFT_ADD(SHIFT_ADD)) u_term_i (
      .x(carrier_i), .w(w_i), .y(term_i)
   );
   qam_scaled_term #(.IN_W(SAMPLE_W), .OUT_W(OUT_W), .SHIFT_ADD(SHIFT_ADD)) u_term_q (
      .x(carrier_q), .w(w_q), .y(term_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample_out <= '0;
      else        sample_out <= term_i + term_q;
   end
endmodule

// File: rtl/qam_comb_checker.sv
module qam_comb_checker #(
   parameter int SAMPLE_W = 12
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       mode_16,
   input logic                       sym_strobe,
   input logic signed [SAMPLE_W-1:0] carrier_i,
   input logic signed [SAMPLE_W-1:0] carrier_q,
   input logic signed [SAMPLE_W+2:0] sample_out,
   input logic [3:0]                 hold_sym
);
   localparam int FS    = 1 << (SAMPLE_W - 1);
   localparam int LIM16 = 6 * FS;
   localparam int LIM4  = 2 * FS;

   logic pv;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   // R9: first edge out of reset still shows the cleared state
   always_ff @(posedge clk) begin
      if (rst_n && !pv) begin
         assert_reset_state_R9: assert (sample_out == '0 && hold_sym == '0)
            else $error("reset state wrong");
      end
   end

   assert_hold_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pv && !sym_strobe |=> $stable(hold_sym));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pv |-> (int'(sample_out) <= LIM16 && int'(sample_out) >= -LIM16));

   assert_qam4_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pv && !mode_16 |=> (int'(sample_out) <= LIM4 && int'(sample_out) >= -LIM4));

   assert_zero_carrier_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pv && carrier_i == '0 && carrier_q == '0 |=> sample_out == '0);
endmodule

bind qam_symbol_combiner qam_comb_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_16(mode_16), .sym_strobe(sym_strobe),
   .carrier_i(carrier_i), .carrier_q(carrier_q), .sample_out(sample_out),
   .hold_sym(hold_sym)
);

// File: tb/tb_qam_symbol_combiner.sv
`timescale 1ns/1ps
module tb_qam_symbol_combiner;
   localparam int SW = 12;
   localparam int OW = SW + 3;
   localparam int FS = 1 << (SW - 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_16 = 1'b0, bit_in = 1'b0, bit_valid = 1'b0, sym_strobe = 1'b0;
   logic signed [SW-1:0] carrier_i = '0, carrier_q = '0;
   logic signed [OW-1:0] sample_out;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   // bench model state
   logic [3:0] m_hold, m_done, m_sr;
   int m_cnt;
   logic m_mode_prev;

   always #5 clk = ~clk;

   qam_symbol_combiner #(.SAMPLE_W(SW)) dut (
      .clk(clk), .rst_n(rst_n), .mode_16(mode_16), .bit_in(bit_in),
      .bit_valid(bit_valid), .sym_strobe(sym_strobe),
      .carrier_i(carrier_i), .carrier_q(carrier_q), .sample_out(sample_out)
   );

   function automatic int w16(input logic [1:0] c);
      int mag = c[0] ? 3 : 1;
      return c[1] ? -mag : mag;
   endfunction

   function automatic int expect_out(input logic [3:0] s, input logic m, input int ci, input int cq);
      int a, b;
      if (m) begin a = w16(s[1:0]); b = w16(s[3:2]); end
      else   begin a = s[1] ? -1 : 1; b = s[0] ? -1 : 1; end
      return a * ci + b * cq;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_hold = '0; m_done = '0; m_sr = '0; m_cnt = 0; m_mode_prev = 1'b0;
   endfunction

   // One clock: drive at negedge, model the edge, sample 1 ns later.
   task automatic step(input logic m, input logic b, input logic v, input logic s,
                       input int ci, input int cq, input string tag);
      int exp, grp;
      mode_16 = m; bit_in = b; bit_valid = v; sym_strobe = s;
      carrier_i = SW'(ci); carrier_q = SW'(cq);
      @(posedge clk);
      exp = expect_out(m_hold, m, ci, cq);
      if (s) m_hold = m_done;
      grp = m ? 4 : 2;
      if (m != m_mode_prev) m_cnt = v ? 1 : 0;
      else if (v) begin
         if (m_cnt + 1 == grp) begin
            m_cnt  = 0;
            m_done = m ? {m_sr[2:0], b} : {2'b00, m_sr[0], b};
         end else m_cnt++;
      end
      if (v) m_sr = {m_sr[2:0], b};
      m_mode_prev = m;
      #1;
      check(tag, int'(sample_out), exp);
      @(negedge clk);
   endtask

   task automatic load_symbol(input logic m, input logic [3:0] sym, input string tag);
      int n = m ? 4 : 2;
      for (int k = n - 1; k >= 0; k--) step(m, sym[k], 1'b1, 1'b0, 0, 0, tag);
      step(m, 1'b0, 1'b0, 1'b1, 0, 0, tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 check("R9 reset output", int'(sample_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: held symbol 0 -> +S0+S1 in both modes
      step(1'b0, 1'b0, 1'b0, 1'b0, 100, 30, "R9");
      step(1'b0, 1'b0, 1'b0, 1'b0, 7, -5, "R9");

      // R2: all 4-QAM symbols
      for (int s = 0; s < 4; s++) begin
         load_symbol(1'b0, 4'(s), "R1");
         step(1'b0, 1'b0, 1'b0, 1'b0, 100, 30, "R2");
         step(1'b0, 1'b0, 1'b0, 1'b0, -FS, FS - 1, "R2");
      end

      // R3/R4: all 16-QAM symbols, plus full-scale negative (R7)
      for (int s = 0; s < 16; s++) begin
         load_symbol(1'b1, 4'(s), "R1");
         step(1'b1, 1'b0, 1'b0, 1'b0, 100, 30, "R3");
         step(1'b1, 1'b0, 1'b0, 1'b0, 11, -200, "R4");
         step(1'b1, 1'b0, 1'b0, 1'b0, -FS, -FS, "R7");
      end

      // R5: bits keep arriving without strobe; held weights stay
      load_symbol(1'b1, 4'b0110, "R5");
      for (int k = 0; k < 8; k++) step(1'b1, k[0], 1'b1, 1'b0, 50, 40, "R5");
      step(1'b1, 1'b0, 1'b0, 1'b1, 50, 40, "R5");
      step(1'b1, 1'b0, 1'b0, 1'b0, 50, 40, "R5");

      // R6: three bits in 16-QAM, switch to 4-QAM, two bits, strobe
      for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, 1'b0, 9, 4, "R6");
      step(1'b0, 1'b0, 1'b1, 1'b0, 9, 4, "R6");
      step(1'b0, 1'b1, 1'b1, 1'b0, 9, 4, "R6");
      step(1'b0, 1'b0, 1'b0, 1'b1, 9, 4, "R6");
      step(1'b0, 1'b0, 1'b0, 1'b0, 9, 4, "R6");

      // R8: random traffic
      begin
         logic m = 1'b0;
         for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 199) == 0) m = ~m;
            step(m, 1'($urandom), ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 5) == 0),
                 int'($signed(SW'($urandom))), int'($signed(SW'($urandom))), "R8");
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule